// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host port and an asynchronous 16-bit static memory that has separate high and low byte enables. The host presents one word request at a time: a read or a write, a 17-bit word address, write data and a two-bit lane mask. The controller turns that request into a strobe sequence on the memory pins. Every interval in the sequence is a whole number of clock cycles, derived at elaboration from nanosecond limits and a clock-period parameter.

A read drives chip select, output enable and the selected byte enables for the whole read phase. The returned word is captured in the last cycle of that phase, and then the memory is given time to release the data bus. A write drives chip select, the byte enables and the data bus for the whole write phase. Write enable is pulsed low at the start of the phase and rises before everything else is released, so the write ends on the write-enable edge. `req_ready` is high only while the controller is idle. `rsp_valid` pulses once when each access completes.

Cycle counts use ceil(ns / CLK_NS), with a minimum of one cycle. With the default 5 ns clock these give:

| Interval | Cycles | Derivation |
|---|---|---|
| Read phase | 9 | longest of 45, 45 and 22 ns |
| Write-enable low | 7 | longest of 35, 25 and 35 ns |
| Write phase | 9 | longest of 45 ns and the write-enable low time plus one cycle |
| Turnaround | 4 | 18 ns |

Top module: `sram_ctl`

## Requirements
- R1: While reset is applied and whenever the controller is idle, `req_ready` is 1. In the same cycles `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are all 1, and `mem_dq_oe` is 0.
- R2: An accepted read holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly the read phase (9 cycles by default), with the address unchanged. `mem_dq_oe` stays 0 while `mem_oe_n` is 0.
- R3: One cycle after the read phase ends, `rsp_valid` is 1 for exactly one cycle. At that point `rsp_rdata` holds the word the memory presented in the last read cycle. Lanes not selected by the mask are forced to zero: bit 1 of the mask selects [15:8] and bit 0 selects [7:0].
- R4: An accepted write holds `mem_ce_n` at 0, holds the selected byte enables at 0 and holds `mem_dq_oe` at 1 for the write phase (9 cycles by default). `mem_we_n` is 0 only for the first 7 cycles. The data are stable for at least ceil(25 ns / CLK_NS) cycles before `mem_we_n` rises, and they are still driven, with chip select still low, in the cycle after it rises.
- R5: One cycle after the write phase ends, `rsp_valid` pulses for one cycle and `req_ready` is 1 again in that same cycle.
- R6: After a read, all strobes stay high for the turnaround time (4 cycles by default) before `req_ready` returns. `mem_dq_oe` never rises fewer than ceil(18 ns / CLK_NS) cycles after `mem_oe_n` has risen.
- R7: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access has fully finished. A request held valid while `req_ready` is 0 is taken only once.
- R8: Whenever `mem_ce_n` is 1, both byte enables are 1. `mem_we_n` is 0 only while `mem_ce_n` is 0.
- R9: A write with mask 2'b00 changes no memory location. A read with mask 2'b00 returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 1 = [15:8], bit 0 = [7:0] |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle pulse when an access completes |
| rsp_rdata | output | 16 | Read data, with unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data the controller drives toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 16 | Data the memory returns |

## Verification
Two things can fall in the same cycle: the completion pulse of a write, and `req_ready` rising to take the next request. A read's completion pulse can also coincide with the start of the turnaround that must delay a following write. The bench provokes both by presenting every request as soon as the previous one is accepted, so `req_valid` is already high when the controller frees up. Mixed read and write pairs are issued back to back in this way. A cycle-level reference model, which knows only the phase lengths, predicts `req_ready`, `rsp_valid` and the returned word on every clock. A behavioural memory attached to the pins separately measures write-enable width, data setup, the turnaround gap and byte-enable behaviour while deselected. It returns a garbage pattern until the access time has elapsed, so sampling even one cycle early shows up as a data mismatch.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW        = 17,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 45,
  parameter int T_AA_NS   = 45,
  parameter int T_DOE_NS  = 22,
  parameter int T_WC_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_SCE_NS  = 35,
  parameter int T_SD_NS   = 25,
  parameter int T_HZOE_NS = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_LEN = imax(ns2cyc(T_RC_NS), imax(ns2cyc(T_AA_NS), ns2cyc(T_DOE_NS)));
  localparam int WE_LOW = imax(ns2cyc(T_PWE_NS), imax(ns2cyc(T_SD_NS), ns2cyc(T_SCE_NS)));
  localparam int WR_LEN = imax(ns2cyc(T_WC_NS), WE_LOW + 1);
  localparam int TA_LEN = ns2cyc(T_HZOE_NS);
  localparam int CW     = $clog2(imax(imax(RD_LEN, WR_LEN), TA_LEN) + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_TURN, S_WR} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [1:0]    be_q;
  logic [15:0]   wdata_q;
  logic [15:0]   lane;

  assign req_ready  = (st == S_IDLE);
  assign mem_dq_out = wdata_q;
  assign lane       = {{8{be_q[1]}}, {8{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cnt      <= '0;
          mem_addr <= req_addr;
          be_q     <= req_be;
          mem_ce_n <= 1'b0;
          mem_ub_n <= ~req_be[1];
          mem_lb_n <= ~req_be[0];
          if (req_write) begin
            st        <= S_WR;
            wdata_q   <= req_wdata;
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
          end else begin
            st       <= S_RD;
            mem_oe_n <= 1'b0;
          end
        end
        S_RD: if (cnt == CW'(RD_LEN - 1)) begin
          rsp_rdata <= mem_dq_in & lane;
          rsp_valid <= 1'b1;
          st        <= S_TURN;
          cnt       <= '0;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
        S_TURN: if (cnt == CW'(TA_LEN - 1)) st <= S_IDLE;
                else cnt <= cnt + CW'(1);
        S_WR: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(WE_LOW - 1)) mem_we_n <= 1'b1;
          if (cnt == CW'(WR_LEN - 1)) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int TA_LEN = 4,
  parameter int WE_LOW = 7
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_ub_n,
  input logic mem_lb_n,
  input logic mem_dq_oe
);

  logic [7:0] oe_hi;
  logic [7:0] we_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi <= 8'hFF;
      we_lo <= 8'h00;
    end else begin
      oe_hi <= !mem_oe_n ? 8'h00 : (oe_hi == 8'hFF ? oe_hi : oe_hi + 8'h01);
      we_lo <= mem_we_n ? 8'h00 : (we_lo == 8'hFF ? we_lo : we_lo + 8'h01);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo >= 8'(WE_LOW)));

  assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi >= 8'(TA_LEN)));

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  assert_be_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_ub_n && mem_lb_n));

  assert_we_inside_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

endmodule

bind sram_ctl sram_ctl_chk #(.TA_LEN(TA_LEN), .WE_LOW(WE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  localparam int E_RD   = (45 + 4) / 5;
  localparam int E_WELO = (35 + 4) / 5;
  localparam int E_WR   = (45 + 4) / 5;
  localparam int E_TA   = (18 + 4) / 5;
  localparam int E_SD   = (25 + 4) / 5;
  localparam int E_AA   = (45 + 4) / 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [15:0] mem_arr [int];
  int rd_cnt = 0, we_run = 0, d_stab = 0, oe_hi = 1000;
  bit prev_rd = 0, prev_we_lo = 0;
  logic [16:0] last_addr = '0;
  logic [15:0] last_dq = '0;
  int v_setup = 0, v_turn = 0, v_desel = 0;
  bit prev_dq_oe = 0;

  function automatic logic [15:0] mrd(input int a);
    return mem_arr.exists(a) ? mem_arr[a] : 16'h0000;
  endfunction

  always @(posedge clk) if (rst_n) begin
    bit rd_act;
    rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (prev_rd && !rd_act) chk(rd_cnt == E_RD, "R2 read strobe length", rd_cnt, E_RD);
    if (rd_act && (rd_cnt == 0 || mem_addr == last_addr)) rd_cnt++;
    else rd_cnt = 0;
    prev_rd = rd_act;

    if (prev_we_lo && mem_we_n) begin
      chk(we_run == E_WELO, "R4 write-enable low length", we_run, E_WELO);
      if (d_stab < E_SD || mem_ce_n || !mem_dq_oe || mem_dq_out != last_dq) v_setup++;
      if (!mem_lb_n) mem_arr[int'(mem_addr)] = {mrd(int'(mem_addr))[15:8], mem_dq_out[7:0]};
      if (!mem_ub_n) mem_arr[int'(mem_addr)] = {mem_dq_out[15:8], mrd(int'(mem_addr))[7:0]};
      we_run = 0;
    end
    if (!mem_we_n) begin
      we_run++;
      if (mem_dq_oe && (we_run == 1 || mem_dq_out == last_dq)) d_stab++;
      else d_stab = 0;
      if (we_run > 1 && mem_addr != last_addr) v_setup++;
    end else d_stab = 0;
    prev_we_lo = !mem_we_n;

    if (mem_dq_oe && !prev_dq_oe && oe_hi < E_TA) v_turn++;
    if (mem_dq_oe && !mem_oe_n) v_turn++;
    if (mem_ce_n && (!mem_ub_n || !mem_lb_n)) v_desel++;
    if (!mem_we_n && mem_ce_n) v_desel++;
    oe_hi = mem_oe_n ? oe_hi + 1 : 0;
    prev_dq_oe = mem_dq_oe;
    last_addr = mem_addr;
    last_dq = mem_dq_out;
  end

  always @(negedge clk) begin
    logic [15:0] w;
    w = mrd(int'(mem_addr));
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_cnt >= E_AA - 1)
      mem_dq_in = {mem_ub_n ? 8'hDE : w[15:8], mem_lb_n ? 8'hAD : w[7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  // ---------------- cycle-level reference model ----------------
  logic [15:0] ref_mem [int];
  bit m_busy = 0, m_wr = 0, exp_done = 0;
  int m_age = 0;
  logic [15:0] m_exp = '0;
  logic [1:0]  m_be = '0;

  function automatic logic [15:0] rrd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  always @(posedge clk) if (rst_n) begin
    exp_done = 0;
    if (!m_busy) begin
      if (req_valid) begin
        m_busy = 1; m_age = 0; m_wr = req_write; m_be = req_be;
        if (req_write) begin
          logic [15:0] o;
          o = rrd(int'(req_addr));
          ref_mem[int'(req_addr)] = {req_be[1] ? req_wdata[15:8] : o[15:8],
                                     req_be[0] ? req_wdata[7:0]  : o[7:0]};
        end else begin
          m_exp = rrd(int'(req_addr)) & {{8{req_be[1]}}, {8{req_be[0]}}};
        end
      end
    end else begin
      m_age++;
      if (m_age == (m_wr ? E_WR : E_RD)) exp_done = 1;
      if (m_wr ? (m_age == E_WR) : (m_age == E_RD + E_TA)) m_busy = 0;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(req_ready == !m_busy, "R7 ready vs model", req_ready, !m_busy);
    chk(rsp_valid == exp_done, m_wr ? "R5 write done pulse" : "R3 read done pulse", rsp_valid, exp_done);
    if (exp_done && !m_wr)
      chk(rsp_rdata == m_exp, (m_be == 2'b00) ? "R9 empty-mask read" : "R3 read data", rsp_rdata, m_exp);
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (m_busy || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 strobes in reset", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 7'b1111110);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);

    send(1, 17'd5, 16'h1234, 2'b11);
    send(0, 17'd5, 16'h0, 2'b11);
    send(1, 17'd5, 16'hABCD, 2'b10);
    send(0, 17'd5, 16'h0, 2'b11);
    send(0, 17'd5, 16'h0, 2'b01);
    send(0, 17'd5, 16'h0, 2'b10);
    send(1, 17'd5, 16'hFFFF, 2'b00);
    send(0, 17'd5, 16'h0, 2'b00);
    send(0, 17'd5, 16'h0, 2'b11);
    drain();
    chk(mem_arr.exists(5) && mem_arr[5] == 16'hAB34, "R9 empty-mask write left word",
        mem_arr.exists(5) ? mem_arr[5] : 16'h0, 16'hAB34);
    send(1, 17'h1FFFF, 16'h5AA5, 2'b11);
    send(1, 17'h00000, 16'hC33C, 2'b01);
    send(0, 17'h1FFFF, 16'h0, 2'b11);
    send(1, 17'h1FFFF, 16'h0F0F, 2'b11);
    send(0, 17'h00000, 16'h0, 2'b11);
    repeat (3) @(negedge clk);
    send(0, 17'h1FFFF, 16'h0, 2'b11);
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      a = (i % 7 == 0) ? 17'($urandom) : 17'($urandom_range(0, 15));
      send($urandom_range(0, 1) == 1, a, 16'($urandom), 2'($urandom));
      if (i % 23 == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    drain();
    chk(v_setup == 0, "R4 write setup or hold violations", v_setup, 0);
    chk(v_turn == 0, "R6 turnaround violations", v_turn, 0);
    chk(v_desel == 0, "R8 deselect violations", v_desel, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule